// File: doc/BRIEF.md
# Ethernet Receive Statistics Counter Unit

This unit sits beside a MAC and turns per-frame status into a bank of event counters. Each received frame arrives as a one-cycle strobe with qualifier bits: short length, bad CRC, carrier ending off an octet boundary, collision during reception, overrun, receive unit without resources, and the save-bad-frames setting. The strobe also carries the frame's EtherType, an address-valid flag and the MAC control opcode. A separate one-cycle strobe marks each pause frame the transmitter sends.

A control stage sorts every frame into categories that exclude each other where required. It emits one increment strobe per counter. A datapath stage holds the counters, saturates them, clears them and serves a combinational read port that is addressed by byte offset. Software reads the counters by driving an address and sampling the data in the same cycle. It zeroes the whole bank by pulsing the clear input.

Top module: `ethstat_top`

## Requirements
- R1: A valid frame with the short bit set increments the short-frame counter (offset 60), and never the alignment counter, whatever its CRC and alignment bits are.
- R2: The alignment counter (offset 44) increments for a valid frame only when the frame is not short, is misaligned and has a bad CRC. A misaligned frame with a good CRC is not counted. The no-resources state does not affect this count.
- R3: The resource counter (offset 48) increments for a valid frame seen while no resources are available. If save-bad-frames is set and the frame is short or has a bad CRC, the counter does not increment.
- R4: The overrun counter (offset 52) counts only the first valid frame of a run of consecutive valid frames that have the overrun bit set. A valid frame without that bit ends the run.
- R5: Every valid frame with the collision bit set increments the collision counter (offset 56).
- R6: Each transmit-pause strobe increments the transmit-pause counter (offset 64). It does so even when no received frame is valid in that cycle.
- R7: A valid frame with EtherType 0x8808, address-valid set and opcode 0x0001 increments the receive-pause counter (offset 68).
- R8: A valid frame with EtherType 0x8808, address-valid set and any opcode other than 0x0001 increments the unsupported-control counter (offset 72). A control frame with address-valid clear increments neither this counter nor the receive-pause counter.
- R9: The read data shows the counter at byte offsets 44 to 72 in steps of 4. Any other address reads zero. Qualifier bits have no effect while frame-valid is low.
- R10: A counter at its all-ones value stays there on further increments.
- R11: A clear pulse zeroes every counter in one cycle. An increment that arrives in the same cycle as the clear is lost.
- R12: After reset every counter reads zero. An event shows in the read data from the clock edge that samples its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Zero all counters |
| frameValid | input | 1 | One-cycle strobe for a received frame's status |
| isShort | input | 1 | Frame below minimum length |
| crcBad | input | 1 | Frame check sequence wrong |
| misaligned | input | 1 | Carrier ended off an octet boundary |
| collision | input | 1 | Collision seen during reception |
| overrun | input | 1 | Frame lost because the system bus was unavailable |
| noResources | input | 1 | Receive unit had no buffers |
| saveBadFrames | input | 1 | Bad frames are kept rather than dropped |
| etherType | input | 16 | Type field of the frame |
| addrValid | input | 1 | Destination address accepted for control frames |
| opcode | input | 16 | MAC control opcode |
| txPause | input | 1 | One-cycle strobe per transmitted pause frame |
| rdAddr | input | 8 | Byte offset of the counter to read |
| rdData | output | 32 | Counter value, zero-extended |

## Verification
Every counter result is due one clock edge after its strobe: the strobe is registered into the counter, and the read mux adds no further delay. The bench drives each strobe for exactly one cycle, starting at a falling edge. It then reads every counter address at later falling edges, each in its own cycle, so the reads always see the state after the update. The bench checks clear against a simultaneous increment after the clock edge that follows it. It checks saturation on a narrow second instance once enough increments have gone in to pass the ceiling.

// File: rtl/ethstat_pkg.sv
package ethstat_pkg;
  localparam int NumCnt = 8;

  typedef enum logic [2:0] {
    CNT_ALIGN, CNT_RES, CNT_OVR, CNT_COL,
    CNT_SHORT, CNT_TXP, CNT_RXP, CNT_UNSUP
  } cntSel_e;

  typedef struct packed {
    logic              clr;
    logic [NumCnt-1:0] inc;
  } cntStrobe_t;

  localparam logic [15:0] MacCtlType  = 16'h8808;
  localparam logic [15:0] PauseOpcode = 16'h0001;
endpackage

// File: rtl/ethstat_ctrl.sv
module ethstat_ctrl
  import ethstat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        frameValid,
  input  logic        isShort,
  input  logic        crcBad,
  input  logic        misaligned,
  input  logic        collision,
  input  logic        overrun,
  input  logic        noResources,
  input  logic        saveBadFrames,
  input  logic [15:0] etherType,
  input  logic        addrValid,
  input  logic [15:0] opcode,
  input  logic        txPause,
  output cntStrobe_t  strobe
);
  logic inOverrun;
  logic ctlFrame;
  logic frameBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           inOverrun <= 1'b0;
    else if (frameValid) inOverrun <= overrun;
  end

  always_comb begin
    ctlFrame = frameValid && addrValid && (etherType == MacCtlType);
    frameBad = isShort || crcBad;
    strobe            = '0;
    strobe.clr        = clear;
    strobe.inc[CNT_ALIGN] = frameValid && !isShort && misaligned && crcBad;
    strobe.inc[CNT_RES]   = frameValid && noResources && !(saveBadFrames && frameBad);
    strobe.inc[CNT_OVR]   = frameValid && overrun && !inOverrun;
    strobe.inc[CNT_COL]   = frameValid && collision;
    strobe.inc[CNT_SHORT] = frameValid && isShort;
    strobe.inc[CNT_TXP]   = txPause;
    strobe.inc[CNT_RXP]   = ctlFrame && (opcode == PauseOpcode);
    strobe.inc[CNT_UNSUP] = ctlFrame && (opcode != PauseOpcode);
  end

  AST_SHORT_NO_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && isShort) |-> !strobe.inc[CNT_ALIGN]); // R1
  AST_ALIGN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc[CNT_ALIGN] |-> (crcBad && misaligned)); // R2
  AST_SAVEBAD_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && saveBadFrames && (isShort || crcBad)) |-> !strobe.inc[CNT_RES]); // R3
  AST_OVR_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc[CNT_OVR] |=> !strobe.inc[CNT_OVR]); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> (strobe.inc & ~(8'd1 << CNT_TXP)) == '0); // R9
endmodule

// File: rtl/ethstat_bank.sv
module ethstat_bank
  import ethstat_pkg::*;
#(
  parameter int CntWidth   = 32,
  parameter int AddrWidth  = 8,
  parameter int BaseOffset = 44,
  parameter int DataWidth  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cntStrobe_t           strobe,
  input  logic [AddrWidth-1:0] rdAddr,
  output logic [DataWidth-1:0] rdData
);
  localparam int IdxW       = $clog2(NumCnt);
  localparam int LastOffset = BaseOffset + 4 * (NumCnt - 1);
  localparam logic [CntWidth-1:0] CntMax = '1;

  logic [CntWidth-1:0]  cnt [NumCnt];
  logic [AddrWidth-1:0] rel;
  logic [IdxW-1:0]      idx;
  logic                 hit;

  for (genvar g = 0; g < NumCnt; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                cnt[g] <= '0;
      else if (strobe.clr)                      cnt[g] <= '0;
      else if (strobe.inc[g] && cnt[g] != CntMax) cnt[g] <= cnt[g] + 1'b1;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      ($past(cnt[g]) == CntMax && !$past(strobe.clr)) |-> cnt[g] == CntMax); // R10
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strobe.clr) |-> (cnt[g] == $past(cnt[g]) ||
                              cnt[g] == CntWidth'($past(cnt[g]) + 1'b1))); // R10
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clr |=> cnt[g] == '0); // R11
  end

  always_comb begin
    rel    = rdAddr - AddrWidth'(BaseOffset);
    idx    = rel[IdxW+1:2];
    hit    = (int'(rdAddr) >= BaseOffset) && (int'(rdAddr) <= LastOffset) &&
             (rdAddr[1:0] == 2'b00);
    rdData = '0;
    if (hit) rdData[CntWidth-1:0] = cnt[idx];
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdAddr) < BaseOffset || int'(rdAddr) > LastOffset) |-> rdData == '0); // R9
endmodule

// File: rtl/ethstat_top.sv
module ethstat_top
  import ethstat_pkg::*;
#(
  parameter int CntWidth = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        frameValid,
  input  logic        isShort,
  input  logic        crcBad,
  input  logic        misaligned,
  input  logic        collision,
  input  logic        overrun,
  input  logic        noResources,
  input  logic        saveBadFrames,
  input  logic [15:0] etherType,
  input  logic        addrValid,
  input  logic [15:0] opcode,
  input  logic        txPause,
  input  logic [7:0]  rdAddr,
  output logic [31:0] rdData
);
  cntStrobe_t strobe;

  ethstat_ctrl u_ctrl (
    .clk, .rstN, .clear, .frameValid, .isShort, .crcBad, .misaligned,
    .collision, .overrun, .noResources, .saveBadFrames, .etherType,
    .addrValid, .opcode, .txPause, .strobe
  );

  ethstat_bank #(.CntWidth(CntWidth), .AddrWidth(8), .BaseOffset(44),
                 .DataWidth(32)) u_bank (
    .clk, .rstN, .strobe, .rdAddr, .rdData
  );
endmodule

// File: tb/ethstat_top_bench.sv
`timescale 1ns/1ps
module ethstat_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 0, frameValid = 0, isShort = 0, crcBad = 0, misaligned = 0;
  logic collision = 0, overrun = 0, noResources = 0, saveBadFrames = 0;
  logic [15:0] etherType = 16'h0800, opcode = 16'h0;
  logic addrValid = 0, txPause = 0;
  logic [7:0] rdAddr = 8'd0;
  logic [31:0] rdData, satData;

  always #4 clk = ~clk;

  ethstat_top u_ethstat_top (
    .clk, .rstN, .clear, .frameValid, .isShort, .crcBad, .misaligned,
    .collision, .overrun, .noResources, .saveBadFrames, .etherType,
    .addrValid, .opcode, .txPause, .rdAddr, .rdData
  );
  ethstat_top #(.CntWidth(3)) u_sat (
    .clk, .rstN, .clear, .frameValid, .isShort, .crcBad, .misaligned,
    .collision, .overrun, .noResources, .saveBadFrames, .etherType,
    .addrValid, .opcode, .txPause, .rdAddr, .rdData(satData)
  );

  // bits: [18]fv [17]short [16]crc [15]mis [14]col [13]ovr [12]nores
  //       [11]save [10:9]ctl [8]tx [7:0] expected increments
  // increment bits: 0 align,1 res,2 ovr,3 col,4 short,5 txp,6 rxp,7 unsup
  localparam int NV = 17;
  localparam logic [18:0] VECS [NV] = '{
    19'b1_0_0_0_0_0_0_0_00_0_00000000,  // good frame
    19'b1_1_1_1_0_0_0_0_00_0_00010000,  // R1 short wins
    19'b1_0_1_1_0_0_1_0_00_0_00000011,  // R2 align while no resources, R3
    19'b1_0_0_1_0_0_0_0_00_0_00000000,  // R2 misaligned, good crc
    19'b1_0_0_0_0_0_1_1_00_0_00000010,  // R3 good frame
    19'b1_0_1_0_0_0_1_1_00_0_00000000,  // R3 bad frame saved
    19'b1_0_0_0_0_1_0_0_00_0_00000100,  // R4 first lost
    19'b1_0_0_0_0_1_0_0_00_0_00000000,  // R4 same run
    19'b1_0_0_0_0_0_0_0_00_0_00000000,  // R4 run ends
    19'b1_0_0_0_0_1_0_0_00_0_00000100,  // R4 new run
    19'b1_0_0_0_1_0_0_0_00_0_00001000,  // R5
    19'b1_0_0_0_0_0_0_0_01_0_01000000,  // R7
    19'b1_0_0_0_0_0_0_0_10_0_10000000,  // R8
    19'b1_0_0_0_0_0_0_0_11_0_00000000,  // R8 bad address
    19'b0_0_0_0_0_0_0_0_00_1_00100000,  // R6 alone
    19'b0_1_0_0_1_0_0_0_00_0_00000000,  // R9 qualifiers ignored
    19'b1_0_0_0_0_0_0_0_01_1_01100000   // R6 R7 together
  };

  int checks = 0, fails = 0;
  int expCnt [8];
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, rdAddr, act, exp);
    end
  endtask

  task automatic readAll(input string req);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rdAddr = 8'(44 + 4 * i);
      #1;
      check(req, rdData, expCnt[i]);
    end
  endtask

  task automatic applyVec(input logic [18:0] v);
    @(negedge clk);
    {frameValid, isShort, crcBad, misaligned, collision, overrun,
     noResources, saveBadFrames} = v[18:11];
    txPause = v[8];
    case (v[10:9])
      2'd0: begin etherType = 16'h0800; addrValid = 1; opcode = 16'h0000; end
      2'd1: begin etherType = 16'h8808; addrValid = 1; opcode = 16'h0001; end
      2'd2: begin etherType = 16'h8808; addrValid = 1; opcode = 16'h0003; end
      default: begin etherType = 16'h8808; addrValid = 0; opcode = 16'h0001; end
    endcase
    @(negedge clk);
    {frameValid, isShort, crcBad, misaligned, collision, overrun,
     noResources, saveBadFrames, txPause, addrValid} = '0;
    for (int i = 0; i < 8; i++) expCnt[i] += int'(v[i]);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) expCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    readAll("R12 reset");

    for (int n = 0; n < NV; n++) begin
      applyVec(VECS[n]);
      readAll($sformatf("R1-row%0d", n) == "" ? "" : $sformatf("vector %0d R1 R2 R3 R4 R5 R6 R7 R8 R9", n));
    end

    // R9 unmapped addresses
    foreach (VECS[k]) begin end
    @(negedge clk); rdAddr = 8'd40; #1; check("R9 below map", rdData, 0);
    @(negedge clk); rdAddr = 8'd76; #1; check("R9 above map", rdData, 0);
    @(negedge clk); rdAddr = 8'd46; #1; check("R9 unaligned", rdData, 0);

    // R11 clear with simultaneous increment
    @(negedge clk); clear = 1; collision = 1; frameValid = 1;
    @(negedge clk); clear = 0; collision = 0; frameValid = 0;
    for (int i = 0; i < 8; i++) expCnt[i] = 0;
    readAll("R11 clear");

    // R10 saturation on narrow instance, R5 on full instance
    for (int k = 0; k < 9; k++) applyVec(19'b1_0_0_0_1_0_0_0_00_0_00001000);
    @(negedge clk); rdAddr = 8'd56; #1;
    check("R10 saturate", satData, 32'd7);
    check("R5 count of nine", rdData, 32'd9);
    applyVec(19'b1_0_0_0_1_0_0_0_00_0_00001000);
    @(negedge clk); rdAddr = 8'd56; #1;
    check("R10 hold at max", satData, 32'd7);
    check("R5 count of ten", rdData, 32'd10);

    done = 1;
    finishRun();
  end
endmodule